// File: doc/BRIEF.md
# Software-Generated Interrupt Target Decoder

This block turns a 64-bit software-generated-interrupt request word, written by one core, into a series of per-element send strobes. It serves N processing elements, and each element has a fixed 32-bit affinity value. The block unpacks the following fields from the word:

- the 4-bit interrupt number;
- three upper affinity bytes;
- a 4-bit range selector;
- a 16-bit target list;
- a routing-mode bit.

The group code and the non-secure flag of the request travel alongside the word.

After a request strobe the block walks the elements one per clock, in index order. Each element that matches gets a one-cycle strobe on its own bit of `send_valid`, together with the interrupt number, group and security flag. In targeted mode an element matches when both of these hold:

- its upper 24 affinity bits equal the three requested bytes;
- its lowest affinity byte falls in the 16-entry window chosen by the range selector, and the matching bit of the target list is set.

In broadcast mode every element except the requester matches.

A busy flag covers the whole walk, and requests that arrive during it are dropped. A one-cycle done pulse marks the last step of the walk, even when nothing matched.

Top module: `sgi_target_decoder`

## Requirements
- R1: The interrupt number is request bits 27:24. The three upper affinity bytes are bits 55:48 (highest), 39:32 and 23:16 (lowest of the three). The target list is bits 15:0.
- R2: The routing-mode bit is request bit 40, where 1 means broadcast. The range selector is bits 47:44 and selects the window of lowest-level affinity values rs*16 to rs*16+15.
- R3: In targeted mode an element is a candidate only when its affinity bits 31:8 equal {bits 55:48, bits 39:32, bits 23:16} of the request.
- R4: A candidate element matches only when its affinity bits 7:0 lie inside the selected window and target-list bit (aff0 - rs*16) is set.
- R5: In broadcast mode every element whose index differs from `req_src` matches, and the affinity fields are ignored.
- R6: At most one bit of `send_valid` is high in any cycle. While any bit is high, `send_intid`, `send_group` and `send_ns` carry the interrupt number, group and flag of the request being walked.
- R7: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. `busy` is high for the next N_PE cycles. Element i is examined on the (i+1)-th edge after acceptance, and its strobe is visible for the cycle that follows that edge.
- R8: A request strobe while `busy` is high is ignored. It neither starts a walk nor changes the walk in progress.
- R9: `done` is high for exactly one cycle, the cycle in which the last element's strobe is visible. `busy` is already low in that cycle. This also happens when no element matches.
- R10: During and after reset, `busy`, `done` and `send_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_word | input | 64 | Software-generated-interrupt request word |
| req_group | input | GROUP_W | Interrupt group code, passed through |
| req_ns | input | 1 | Non-secure flag, passed through |
| req_src | input | IDX_W | Index of the requesting element |
| pe_affinity | input | 32*N_PE | Fixed affinity of each element; element i occupies bits 32*i+31:32*i |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| send_valid | output | N_PE | Per-element send strobe |
| send_intid | output | 4 | Interrupt number for the strobe |
| send_group | output | GROUP_W | Group code for the strobe |
| send_ns | output | 1 | Non-secure flag for the strobe |

## Verification
The assertions check these properties on every cycle:

- at most one send strobe is high;
- strobes appear only after a busy cycle;
- `done` follows a busy cycle, falls with `busy`, and never lasts two cycles;
- a walk starts only after a request strobe.

Only the bench's scenarios can show which elements a given word selects:

- the window and target-list decoding;
- broadcast exclusion of the requester;
- the exact cycle of each strobe;
- that a strobe during a walk leaves the result untouched.

The bench's cycle-by-cycle model checks all of these against every output on every clock.

// File: rtl/sgi_pkg.sv
// Package: shared field layout and decoded request type for the
// software-generated-interrupt target decoder.
// Assumes a 64-bit request word and 32-bit element affinities.
package sgi_pkg;
    localparam int WORD_W  = 64;
    localparam int AFF_W   = 32;
    localparam int TLIST_W = 16;
    localparam int INTID_W = 4;
    localparam int RS_W    = 4;

    // Bit positions the decoder depends on
    localparam int INTID_LSB = 24;
    localparam int AFF3_LSB  = 48;
    localparam int AFF2_LSB  = 32;
    localparam int AFF1_LSB  = 16;
    localparam int RS_LSB    = 44;
    localparam int BCAST_BIT = 40;

    typedef struct packed {
        logic [INTID_W-1:0] intid;
        logic [7:0]         aff3;
        logic [7:0]         aff2;
        logic [7:0]         aff1;
        logic [RS_W-1:0]    rs;
        logic [TLIST_W-1:0] tlist;
        logic               bcast;
    } sgi_req_t;
endpackage

// File: rtl/sgi_req_decode.sv
// Module: sgi_req_decode
// Splits a raw request word into its fields. Purely combinational.
// Assumes the field positions given in sgi_pkg.
module sgi_req_decode
    import sgi_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output sgi_req_t          fields
);
    // Field extraction
    always_comb begin
        fields.intid = word[INTID_LSB +: INTID_W];
        fields.aff3  = word[AFF3_LSB +: 8];
        fields.aff2  = word[AFF2_LSB +: 8];
        fields.aff1  = word[AFF1_LSB +: 8];
        fields.rs    = word[RS_LSB +: RS_W];
        fields.tlist = word[TLIST_W-1:0];
        fields.bcast = word[BCAST_BIT];
    end
endmodule

// File: rtl/sgi_pe_match.sv
// Module: sgi_pe_match
// Decides whether one element is a destination of a decoded request.
// Assumes the window width equals the target-list width (16), so the
// window is picked by the upper nibble of the lowest affinity byte.
module sgi_pe_match
    import sgi_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  sgi_req_t         req,
    input  logic [AFF_W-1:0] pe_aff,
    input  logic [IDX_W-1:0] pe_idx,
    input  logic [IDX_W-1:0] src_idx,
    output logic             hit
);
    logic       upper_eq;
    logic       in_window;
    logic [3:0] offset;

    // Targeted-mode and broadcast-mode match terms
    always_comb begin
        upper_eq  = (pe_aff[AFF_W-1:8] == {req.aff3, req.aff2, req.aff1});
        in_window = (pe_aff[7:4] == req.rs);
        offset    = pe_aff[3:0];
        if (req.bcast) begin
            hit = (pe_idx != src_idx);
        end else begin
            hit = upper_eq && in_window && req.tlist[offset];
        end
    end
endmodule

// File: rtl/sgi_scan_ctrl.sv
// Module: sgi_scan_ctrl
// Sequencer that walks element indices 0..N_PE-1, one per clock, after
// a start. Raises done on the last step. Starts are ignored while busy.
module sgi_scan_ctrl #(
    parameter int N_PE  = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [IDX_W-1:0] idx,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_PE - 1);

    // Walk state: busy flag, current index, completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (idx == LAST_IDX) begin
                    busy <= 1'b0;
                    idx  <= '0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end else if (start) begin
                busy <= 1'b1;
                idx  <= '0;
            end
        end
    end
endmodule

// File: rtl/sgi_target_decoder.sv
// Module: sgi_target_decoder (top)
// Latches an accepted software-generated-interrupt request. A single
// shared matcher then examines one element per clock, and a registered
// one-hot send strobe is raised for each matching element.
// Assumes pe_affinity is static while a walk is in progress.
module sgi_target_decoder
    import sgi_pkg::*;
#(
    parameter int N_PE    = 8,
    parameter int GROUP_W = 2,
    localparam int IDX_W  = (N_PE > 1) ? $clog2(N_PE) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [WORD_W-1:0]     req_word,
    input  logic [GROUP_W-1:0]    req_group,
    input  logic                  req_ns,
    input  logic [IDX_W-1:0]      req_src,
    input  logic [AFF_W*N_PE-1:0] pe_affinity,
    output logic                  busy,
    output logic                  done,
    output logic [N_PE-1:0]       send_valid,
    output logic [INTID_W-1:0]    send_intid,
    output logic [GROUP_W-1:0]    send_group,
    output logic                  send_ns
);
    sgi_req_t           dec_req;
    sgi_req_t           req_q;
    logic [GROUP_W-1:0] group_q;
    logic               ns_q;
    logic [IDX_W-1:0]   src_q;
    logic [IDX_W-1:0]   scan_idx;
    logic [AFF_W-1:0]   cur_aff;
    logic               cur_hit;
    logic               accept;
    logic [N_PE-1:0]    idx_onehot;

    assign accept = req_valid && !busy;

    sgi_req_decode u_decode (
        .word   (req_word),
        .fields (dec_req)
    );

    sgi_scan_ctrl #(.N_PE(N_PE), .IDX_W(IDX_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .busy  (busy),
        .idx   (scan_idx),
        .done  (done)
    );

    // Request capture on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= '0;
            group_q <= '0;
            ns_q    <= 1'b0;
            src_q   <= '0;
        end else if (accept) begin
            req_q   <= dec_req;
            group_q <= req_group;
            ns_q    <= req_ns;
            src_q   <= req_src;
        end
    end

    // Affinity of the element under examination
    always_comb begin
        cur_aff = pe_affinity[scan_idx*AFF_W +: AFF_W];
    end

    sgi_pe_match #(.IDX_W(IDX_W)) u_match (
        .req     (req_q),
        .pe_aff  (cur_aff),
        .pe_idx  (scan_idx),
        .src_idx (src_q),
        .hit     (cur_hit)
    );

    // One-hot decode of the scan index
    for (genvar g = 0; g < N_PE; g++) begin : g_onehot
        assign idx_onehot[g] = (scan_idx == IDX_W'(g));
    end

    // Registered send strobe and payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            send_valid <= '0;
            send_intid <= '0;
            send_group <= '0;
            send_ns    <= 1'b0;
        end else begin
            send_valid <= (busy && cur_hit) ? idx_onehot : '0;
            send_intid <= req_q.intid;
            send_group <= group_q;
            send_ns    <= ns_q;
        end
    end
endmodule

// File: rtl/sgi_target_decoder_chk.sv
// Module: sgi_target_decoder_chk
// Checker of port-level properties, bound to sgi_target_decoder.
module sgi_target_decoder_chk #(
    parameter int N_PE = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            busy,
    input logic            done,
    input logic [N_PE-1:0] send_valid
);
    p_send_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(send_valid));

    p_send_in_walk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|send_valid) |-> $past(busy));

    p_done_ends_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_start_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
endmodule

bind sgi_target_decoder sgi_target_decoder_chk #(.N_PE(N_PE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .busy       (busy),
    .done       (done),
    .send_valid (send_valid)
);

// File: tb/tb_sgi_target_decoder.sv
module tb_sgi_target_decoder;
    localparam int N  = 8;
    localparam int IW = 3;
    localparam int GW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [63:0]   req_word = '0;
    logic [GW-1:0] req_group = '0;
    logic          req_ns = 1'b0;
    logic [IW-1:0] req_src = '0;
    logic [32*N-1:0] pe_affinity;
    logic          busy, done, send_ns;
    logic [N-1:0]  send_valid;
    logic [3:0]    send_intid;
    logic [GW-1:0] send_group;

    logic [31:0] aff [N];
    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    string cur_tag = "R10";

    // reference model state
    bit          m_busy = 0;
    int          m_idx = 0;
    logic [63:0] m_word = '0;
    logic [GW-1:0] m_grp = '0;
    bit          m_ns = 0;
    int          m_src = 0;
    logic [N-1:0] e_send = '0;
    bit          e_done = 0;

    always #2.5 clk = ~clk;

    sgi_target_decoder #(.N_PE(N), .GROUP_W(GW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
        .req_group(req_group), .req_ns(req_ns), .req_src(req_src),
        .pe_affinity(pe_affinity), .busy(busy), .done(done),
        .send_valid(send_valid), .send_intid(send_intid),
        .send_group(send_group), .send_ns(send_ns)
    );

    initial begin
        aff[0] = 32'h0102_0305;
        aff[1] = 32'h0102_0312;
        aff[2] = 32'h0102_030F;
        aff[3] = 32'h0102_0405;
        aff[4] = 32'h0102_0300;
        aff[5] = 32'h0102_03FF;
        aff[6] = 32'h0102_031F;
        aff[7] = 32'h0202_0300;
    end
    always_comb for (int i = 0; i < N; i++) pe_affinity[32*i +: 32] = aff[i];

    function automatic bit ref_hit(int i);
        logic [31:0] a = aff[i];
        int lo;
        if (m_word[40]) return i != m_src;
        if (a[31:8] != {m_word[55:48], m_word[39:32], m_word[23:16]}) return 0;
        lo = int'(m_word[47:44]) * 16;
        if (int'(a[7:0]) < lo || int'(a[7:0]) > lo + 15) return 0;
        return m_word[int'(a[7:0]) - lo];
    endfunction

    // behavioural reference, advanced on every clock
    always @(posedge clk) begin
        e_send = '0;
        e_done = 0;
        if (!rst_n) begin
            m_busy = 0;
            m_idx = 0;
        end else if (m_busy) begin
            if (ref_hit(m_idx)) e_send[m_idx] = 1'b1;
            if (m_idx == N - 1) begin
                m_busy = 0;
                e_done = 1;
            end else m_idx++;
        end else if (req_valid) begin
            m_word = req_word; m_grp = req_group; m_ns = req_ns;
            m_src = int'(req_src); m_busy = 1; m_idx = 0;
        end
    end

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    // compare every output against the model away from the active edge
    always @(negedge clk) begin
        cycles++;
        check("R7 busy", 64'(busy), 64'(m_busy));
        check("R9 done", 64'(done), 64'(e_done));
        check({cur_tag, " send_valid"}, 64'(send_valid), 64'(e_send));
        if (e_send != 0) begin
            check("R6 intid", 64'(send_intid), 64'(m_word[27:24]));
            check("R6 group", 64'(send_group), 64'(m_grp));
            check("R6 ns", 64'(send_ns), 64'(m_ns));
        end
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    function automatic logic [63:0] mk(logic [7:0] a3, logic [7:0] a2, logic [7:0] a1,
                                       logic [3:0] rs, logic bc, logic [3:0] id,
                                       logic [15:0] tl);
        return {8'h00, a3, rs, 3'b000, bc, a2, 4'h0, id, a1, tl};
    endfunction

    task automatic issue(logic [63:0] w, logic [GW-1:0] g, logic ns, int src);
        @(negedge clk);
        req_valid = 1; req_word = w; req_group = g; req_ns = ns; req_src = IW'(src);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic drain();
        repeat (N + 3) @(negedge clk);
    endtask

    logic [63:0] lfsr = 64'h1234_5678_9ABC_DEF1;

    initial begin
        cur_tag = "R10";
        repeat (3) @(negedge clk);
        check("R10 busy", 64'(busy), 64'd0);
        check("R10 send", 64'(send_valid), 64'd0);
        rst_n = 1;
        @(negedge clk);
        // R1: rs=0, target bits 0,5,15 -> elements 4,0,2
        cur_tag = "R1";
        issue(mk(8'h01, 8'h02, 8'h03, 4'h0, 1'b0, 4'hA, 16'h8021), 2'd1, 1'b1, 0);
        drain();
        // R4: window 1, bits 2 and 15 -> elements 1 and 6
        cur_tag = "R4";
        issue(mk(8'h01, 8'h02, 8'h03, 4'h1, 1'b0, 4'h3, 16'h8004), 2'd2, 1'b0, 1);
        drain();
        // R2: top window, bit 15 -> element 5 only
        cur_tag = "R2";
        issue(mk(8'h01, 8'h02, 8'h03, 4'hF, 1'b0, 4'h7, 16'h8000), 2'd0, 1'b1, 2);
        drain();
        // R3: upper affinity matches nobody -> done only
        cur_tag = "R3";
        issue(mk(8'h99, 8'h99, 8'h99, 4'h0, 1'b0, 4'h1, 16'hFFFF), 2'd3, 1'b0, 0);
        drain();
        // R3: level-1 byte 04 selects element 3 only
        issue(mk(8'h01, 8'h02, 8'h04, 4'h0, 1'b0, 4'h2, 16'hFFFF), 2'd1, 1'b0, 0);
        drain();
        // R5: broadcast from element 3, affinity fields garbage
        cur_tag = "R5";
        issue(mk(8'hEE, 8'hEE, 8'hEE, 4'h9, 1'b1, 4'hC, 16'h0000), 2'd1, 1'b1, 3);
        drain();
        // R8: second strobe while busy must be ignored
        cur_tag = "R8";
        issue(mk(8'h01, 8'h02, 8'h03, 4'h0, 1'b0, 4'h5, 16'h0020), 2'd0, 1'b0, 0);
        @(negedge clk);
        req_valid = 1; req_word = mk(8'h01, 8'h02, 8'h03, 4'h0, 1'b1, 4'hF, 16'hFFFF);
        req_src = 3'd7;
        @(negedge clk);
        req_valid = 0;
        drain();
        // R1: mixed pseudo-random words, half with the common upper affinity
        cur_tag = "R1";
        for (int k = 0; k < 24; k++) begin
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
            if (k % 2 == 0) begin
                lfsr[55:48] = 8'h01; lfsr[39:32] = 8'h02; lfsr[23:16] = 8'h03;
                lfsr[40] = (k % 6 == 0);
            end
            issue(lfsr, lfsr[61:60], lfsr[62], int'(lfsr[58:56]));
            drain();
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule